// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This block turns the packed partial remainders of one BCH codeword into the complete set of 2t field syndromes that a key-equation solver needs. Each remainder feeds one odd-indexed syndrome. That syndrome is built by XOR-accumulating powers of the primitive element, one for every set bit of the remainder. Each even-indexed syndrome is the square of a lower-index syndrome. The block forms that square with a log lookup, a doubled exponent reduced modulo 2^m−1, and an antilog lookup.

The field tables are held outside the block. The block reaches them through a single read port with one cycle of latency, and that one port serves both the power table and the log table. A run begins with a start pulse. The block latches the correction capability t and the field degree, clears its syndrome file, walks the remainders, then derives the even syndromes in ascending order. It then holds done high together with a stable syndrome file until the next start. The remainder bank must stay stable for the whole run.

Top module: `bch_syn_expand`

## Requirements
- R1: After reset, busy_o and done_o are low and every syndrome in syn_o reads zero.
- R2: A start_i pulse while the block is idle or done clears the whole syndrome file. In the next cycle busy_o is high, done_o is low and syn_o is all zero.
- R3: Remainder k (k = 0..t−1) is taken from 32-bit word k/2 of rem_i: bits [15:0] when k is even, bits [31:16] when k is odd. Only its low m bits take part, so bits 14 and 15 (and bit 13 when m is 13) have no effect on any syndrome.
- R4: Remainder k produces syndrome S(2k+1), the XOR of alpha^((2k+1)·j mod (2^m−1)) over every set bit j < m of that remainder.
- R5: For j = 1..t, S(2j) is zero when S(j) is zero. Otherwise it is power[(2·log S(j)) mod (2^m−1)], which equals S(j) squared.
- R6: m14_i = 0 selects m = 13 (polynomial x^13+x^4+x^3+x+1, modulus 8191). m14_i = 1 selects m = 14 (polynomial x^14+x^10+x^6+x+1, modulus 16383).
- R7: Syndrome indices above 2t read zero when done_o is high.
- R8: done_o stays high, and syn_o stays unchanged, until the next start_i. A start_i pulse while busy_o is high is ignored.
- R9: Table port: a request on tbl_req_o is answered on tbl_data_i in the following cycle. tbl_log_o = 1 selects the log table and 0 selects the power table. Power addresses are always below 2^m−1, log requests never use address 0, and no request is made while idle.
- R10: A t_i of 0 is treated as 1, and a t_i above T_MAX is treated as T_MAX.
- R11: syn_o carries syndrome i (1..2·T_MAX) in bits [(i−1)·14 +: 14]. Syndromes are 14 bits wide and zero-extended when m is 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the block is not busy |
| t_i | input | 5 | Correction capability t |
| m14_i | input | 1 | Field degree select: 0 gives m = 13, 1 gives m = 14 |
| rem_i | input | 384 | Bank of 32-bit partial remainder words, two remainders per word |
| tbl_req_o | output | 1 | Table read request |
| tbl_log_o | output | 1 | Table select: 1 = log, 0 = power |
| tbl_addr_o | output | 14 | Table address |
| tbl_data_i | input | 14 | Table read data, one cycle after the request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | All syndromes valid |
| syn_o | output | 672 | Syndrome file, entries 1..2·T_MAX |

## Verification
The hardest case to reach from the ports is a zero odd syndrome produced by nonzero remainder bits that cancel, alongside the plain zero-remainder case. Both must take the path that bypasses the log lookup for the following even syndromes. A chain of even squarings also has to reach S(4), S(8) and S(16) from a single nonzero S(1). The stimulus forces these paths with directed runs: all-zero banks, single-bit remainders and banks whose only set bits lie above m. It then mixes in seeded random banks with random t under both field sizes, and a start pulse in the middle of a run. A bench field model checks every square independently by direct multiplication, without using the log and power path the block relies on.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;
  localparam int unsigned SW = 14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ODD, ST_DRAIN, ST_EV_CHK, ST_EV_LOG, ST_EV_POW, ST_DONE
  } syn_state_e;

  function automatic logic [SW-1:0] cw_len(input logic m14);
    return m14 ? SW'(16383) : SW'(8191);
  endfunction

  // a + b reduced once modulo n; both operands already below n
  function automatic logic [SW-1:0] add_mod(input logic [SW-1:0] a,
                                             input logic [SW-1:0] b,
                                             input logic [SW-1:0] n);
    logic [SW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[SW-1:0];
  endfunction
endpackage

// File: rtl/bch_syn_unpack.sv
module bch_syn_unpack #(
  parameter int unsigned T_MAX = 24,
  parameter int unsigned NW    = (T_MAX + 1) / 2,
  parameter int unsigned TW    = $clog2(T_MAX + 1)
) (
  input  logic [NW*32-1:0] rem_i,
  input  logic [TW-1:0]    k_i,
  input  logic [3:0]       j_i,
  output logic             bit_o
);
  logic [15:0] half [T_MAX];

  for (genvar g = 0; g < T_MAX; g++) begin : g_half
    assign half[g] = rem_i[(g/2)*32 + (g%2)*16 +: 16];
  end

  always_comb begin
    bit_o = 1'b0;
    for (int g = 0; g < T_MAX; g++)
      if (k_i == TW'(g)) bit_o = half[g][j_i];
  end
endmodule

// File: rtl/bch_syn_file.sv
module bch_syn_file import bch_syn_pkg::*; #(
  parameter int unsigned NS = 48,
  parameter int unsigned IW = $clog2(NS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_en_i,
  input  logic [IW-1:0]    acc_idx_i,
  input  logic [SW-1:0]    acc_data_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [SW-1:0]    wr_data_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [SW-1:0]    rd_data_o,
  output logic [NS*SW-1:0] syn_o
);
  logic [SW-1:0] syn_q [NS];

  // entry g holds syndrome index g+1
  for (genvar g = 0; g < NS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    syn_q[g] <= '0;
      else if (clr_i)                                 syn_q[g] <= '0;
      else if (acc_en_i && acc_idx_i == IW'(g + 1))   syn_q[g] <= syn_q[g] ^ acc_data_i;
      else if (wr_en_i && wr_idx_i == IW'(g + 1))     syn_q[g] <= wr_data_i;
    end
    assign syn_o[g*SW +: SW] = syn_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < NS; g++)
      if (rd_idx_i == IW'(g + 1)) rd_data_o = syn_q[g];
  end
endmodule

// File: rtl/bch_syn_seq.sv
module bch_syn_seq import bch_syn_pkg::*; #(
  parameter int unsigned T_MAX = 24,
  parameter int unsigned TW    = $clog2(T_MAX + 1),
  parameter int unsigned IW    = $clog2(2 * T_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] t_i,
  input  logic          m14_i,
  input  logic          bit_i,
  output logic [TW-1:0] k_o,
  output logic [3:0]    j_o,
  output logic          m14_o,
  output logic          tbl_req_o,
  output logic          tbl_log_o,
  output logic [SW-1:0] tbl_addr_o,
  input  logic [SW-1:0] tbl_data_i,
  output logic          clr_o,
  output logic          acc_en_o,
  output logic [IW-1:0] acc_idx_o,
  output logic [SW-1:0] acc_data_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [SW-1:0] wr_data_o,
  output logic [IW-1:0] rd_idx_o,
  input  logic [SW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o
);
  syn_state_e    state_q;
  logic [TW-1:0] t_q, k_q, ev_q;
  logic [3:0]    j_q;
  logic [SW-1:0] e_q;
  logic          m14_q, pend_v_q;
  logic [IW-1:0] pend_idx_q, odd_idx;
  logic [SW-1:0] n_len;
  logic [TW-1:0] t_clamp;
  logic          idle, last_bit, ev_last;

  assign n_len    = cw_len(m14_q);
  assign idle     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign odd_idx  = IW'({k_q, 1'b1});
  assign last_bit = (j_q == (m14_q ? 4'd13 : 4'd12));
  assign ev_last  = (ev_q == t_q);
  assign t_clamp  = (t_i == '0) ? TW'(1) : (t_i > TW'(T_MAX)) ? TW'(T_MAX) : t_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; t_q <= TW'(1); m14_q <= 1'b0;
      k_q <= '0; j_q <= '0; e_q <= '0; ev_q <= '0;
      pend_v_q <= 1'b0; pend_idx_q <= '0;
    end else begin
      pend_v_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_ODD; t_q <= t_clamp; m14_q <= m14_i;
          k_q <= '0; j_q <= '0; e_q <= '0;
        end
        ST_ODD: begin
          pend_v_q   <= bit_i;
          pend_idx_q <= odd_idx;
          if (last_bit) begin
            j_q <= '0; e_q <= '0;
            if (k_q == t_q - TW'(1)) state_q <= ST_DRAIN;
            else                     k_q <= k_q + TW'(1);
          end else begin
            j_q <= j_q + 4'd1;
            e_q <= add_mod(e_q, SW'(odd_idx), n_len);
          end
        end
        ST_DRAIN: begin ev_q <= TW'(1); state_q <= ST_EV_CHK; end
        ST_EV_CHK: begin
          if (rd_data_i != '0)  state_q <= ST_EV_LOG;
          else if (ev_last)     state_q <= ST_DONE;
          else                  ev_q <= ev_q + TW'(1);
        end
        ST_EV_LOG: state_q <= ST_EV_POW;
        ST_EV_POW: begin
          if (ev_last) state_q <= ST_DONE;
          else begin ev_q <= ev_q + TW'(1); state_q <= ST_EV_CHK; end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tbl_req_o  = 1'b0;
    tbl_log_o  = 1'b0;
    tbl_addr_o = '0;
    unique case (state_q)
      ST_ODD:    begin tbl_req_o = bit_i; tbl_addr_o = e_q; end
      ST_EV_CHK: begin tbl_req_o = (rd_data_i != '0); tbl_log_o = 1'b1; tbl_addr_o = rd_data_i; end
      ST_EV_LOG: begin tbl_req_o = 1'b1; tbl_addr_o = add_mod(tbl_data_i, tbl_data_i, n_len); end
      default: ;
    endcase
  end

  assign clr_o      = idle && start_i;
  assign acc_en_o   = pend_v_q;
  assign acc_idx_o  = pend_idx_q;
  assign acc_data_o = tbl_data_i;
  assign wr_en_o    = ((state_q == ST_EV_CHK) && (rd_data_i == '0)) || (state_q == ST_EV_POW);
  assign wr_idx_o   = IW'({ev_q, 1'b0});
  assign wr_data_o  = (state_q == ST_EV_POW) ? tbl_data_i : '0;
  assign rd_idx_o   = IW'(ev_q);
  assign k_o        = k_q;
  assign j_o        = j_q;
  assign m14_o      = m14_q;
  assign busy_o     = !idle;
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/bch_syn_expand.sv
module bch_syn_expand import bch_syn_pkg::*; #(
  parameter int unsigned T_MAX = 24,
  localparam int unsigned NW    = (T_MAX + 1) / 2,
  localparam int unsigned TW    = $clog2(T_MAX + 1),
  localparam int unsigned NS    = 2 * T_MAX,
  localparam int unsigned IW    = $clog2(NS + 1),
  localparam int unsigned SYN_W = NS * SW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TW-1:0]    t_i,
  input  logic             m14_i,
  input  logic [NW*32-1:0] rem_i,
  output logic             tbl_req_o,
  output logic             tbl_log_o,
  output logic [SW-1:0]    tbl_addr_o,
  input  logic [SW-1:0]    tbl_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [SYN_W-1:0] syn_o
);
  logic [TW-1:0] k_w;
  logic [3:0]    j_w;
  logic          bit_w, m14_q;
  logic          clr_w, acc_en_w, wr_en_w;
  logic [IW-1:0] acc_idx_w, wr_idx_w, rd_idx_w;
  logic [SW-1:0] acc_data_w, wr_data_w, rd_data_w;

  bch_syn_unpack #(.T_MAX(T_MAX), .NW(NW), .TW(TW)) u_unpack (
    .rem_i(rem_i), .k_i(k_w), .j_i(j_w), .bit_o(bit_w)
  );

  bch_syn_seq #(.T_MAX(T_MAX), .TW(TW), .IW(IW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .t_i(t_i), .m14_i(m14_i),
    .bit_i(bit_w), .k_o(k_w), .j_o(j_w), .m14_o(m14_q),
    .tbl_req_o(tbl_req_o), .tbl_log_o(tbl_log_o), .tbl_addr_o(tbl_addr_o),
    .tbl_data_i(tbl_data_i), .clr_o(clr_w), .acc_en_o(acc_en_w),
    .acc_idx_o(acc_idx_w), .acc_data_o(acc_data_w), .wr_en_o(wr_en_w),
    .wr_idx_o(wr_idx_w), .wr_data_o(wr_data_w), .rd_idx_o(rd_idx_w),
    .rd_data_i(rd_data_w), .busy_o(busy_o), .done_o(done_o)
  );

  bch_syn_file #(.NS(NS), .IW(IW)) u_file (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_w),
    .acc_en_i(acc_en_w), .acc_idx_i(acc_idx_w), .acc_data_i(acc_data_w),
    .wr_en_i(wr_en_w), .wr_idx_i(wr_idx_w), .wr_data_i(wr_data_w),
    .rd_idx_i(rd_idx_w), .rd_data_o(rd_data_w), .syn_o(syn_o)
  );
endmodule

// File: rtl/bch_syn_chk.sv
module bch_syn_chk import bch_syn_pkg::*; #(
  parameter int unsigned SYN_W = 672
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             tbl_req_o,
  input logic             tbl_log_o,
  input logic [SW-1:0]    tbl_addr_o,
  input logic             m14_q,
  input logic [SYN_W-1:0] syn_o
);
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o && syn_o == '0));

  assert_pow_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_req_o && !tbl_log_o) |-> (tbl_addr_o < cw_len(m14_q)));

  assert_log_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_req_o && tbl_log_o) |-> (tbl_addr_o != '0));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_req_o |-> busy_o);

  assert_done_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(syn_o)));
endmodule

bind bch_syn_expand bch_syn_chk #(.SYN_W(SYN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .tbl_req_o(tbl_req_o), .tbl_log_o(tbl_log_o),
  .tbl_addr_o(tbl_addr_o), .m14_q(m14_q), .syn_o(syn_o)
);

// File: tb/sim_bch_syn_expand.sv
module sim_bch_syn_expand;
  localparam int CLK_PERIOD = 10;
  localparam int T_MAX = 24;
  localparam int NW = (T_MAX + 1) / 2;
  localparam int NS = 2 * T_MAX;
  localparam int SW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] t_in = 5'd1;
  logic m14_in = 1'b0;
  logic [NW*32-1:0] rem_in = '0;
  logic tbl_req, tbl_log;
  logic [SW-1:0] tbl_addr;
  logic [SW-1:0] tbl_data = '0;
  logic busy, done;
  logic [NS*SW-1:0] syn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tbl_bad = 0;
  int es [NS+1];

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_syn_expand #(.T_MAX(T_MAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .t_i(t_in), .m14_i(m14_in),
    .rem_i(rem_in), .tbl_req_o(tbl_req), .tbl_log_o(tbl_log), .tbl_addr_o(tbl_addr),
    .tbl_data_i(tbl_data), .busy_o(busy), .done_o(done), .syn_o(syn)
  );

  function automatic int mulx(input int x, input bit m14);
    int m, p, r;
    m = m14 ? 14 : 13;
    p = m14 ? 'h4443 : 'h201b;
    r = x << 1;
    if (((r >> m) & 1) != 0) r = r ^ p;
    return r;
  endfunction

  function automatic int apow(input int e, input bit m14);
    int x = 1;
    for (int i = 0; i < e; i++) x = mulx(x, m14);
    return x;
  endfunction

  function automatic int alog(input int a, input bit m14);
    int x = 1;
    int n = m14 ? 16383 : 8191;
    for (int e = 0; e < n; e++) begin
      if (x == a) return e;
      x = mulx(x, m14);
    end
    return 0;
  endfunction

  function automatic int gmul(input int a, input int b, input bit m14);
    int r = 0;
    int m = m14 ? 14 : 13;
    for (int i = m - 1; i >= 0; i--) begin
      r = mulx(r, m14);
      if (((b >> i) & 1) != 0) r = r ^ a;
    end
    return r;
  endfunction

  // field table model, one cycle latency; R9 protocol monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tbl_req) begin
      if (tbl_log) begin
        if (tbl_addr == 0) tbl_bad <= tbl_bad + 1;
        tbl_data <= SW'(alog(int'(tbl_addr), m14_in));
      end else begin
        if (int'(tbl_addr) >= (m14_in ? 16383 : 8191)) tbl_bad <= tbl_bad + 1;
        tbl_data <= SW'(apow(int'(tbl_addr), m14_in));
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors = errors + 1;
    $display("FAIL watchdog: act cycles %0d exp below 150000", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compute(input int t, input bit m14, input logic [NW*32-1:0] rem);
    int m = m14 ? 14 : 13;
    int n = m14 ? 16383 : 8191;
    for (int i = 0; i <= NS; i++) es[i] = 0;
    for (int k = 0; k < t; k++) begin
      logic [15:0] h;
      h = rem[(k/2)*32 + (k%2)*16 +: 16];
      for (int j = 0; j < m; j++)
        if (h[j]) es[2*k+1] = es[2*k+1] ^ apow(((2*k+1)*j) % n, m14);
    end
    for (int j = 1; j <= t; j++) es[2*j] = gmul(es[j], es[j], m14);
  endtask

  task automatic run(input int t, input bit m14, input logic [NW*32-1:0] rem,
                     input bit poke, input string tag);
    int te, w;
    logic [NS*SW-1:0] snap;
    te = (t == 0) ? 1 : (t > T_MAX ? T_MAX : t);
    @(negedge clk);
    t_in = 5'(t); m14_in = m14; rem_in = rem; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && syn == '0, "R2", {tag, " clear on start"}, {busy, done, |syn}, 3'b100);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R8", {tag, " start while busy ignored"}, busy, 1);
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done, "R8", {tag, " done reached"}, done, 1);
    compute(te, m14, rem);
    for (int i = 1; i <= NS; i++) begin
      int act, exp;
      string rq;
      act = int'(syn[(i-1)*SW +: SW]);
      exp = (i <= 2*te) ? es[i] : 0;
      rq = (i > 2*te) ? "R7" : ((i % 2) == 1 ? "R4" : "R5");
      chk(act == exp, rq, $sformatf("%s R11 idx %0d", tag, i), act, exp);
    end
    snap = syn;
    repeat (3) @(negedge clk);
    chk(done && syn == snap, "R8", {tag, " hold after done"}, done, 1);
  endtask

  initial begin
    int unsigned sd;
    logic [NW*32-1:0] r;
    sd = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(!busy && !done && syn == '0, "R1", "reset state", {busy, done, |syn}, 0);
    rst_n = 1'b1;

    run(24, 1'b0, '0, 1'b0, "R5 all-zero m13");
    r = '0; r[0] = 1'b1;
    run(8, 1'b0, r, 1'b0, "R4 S1=1 chain");
    r = '0; r[16+3] = 1'b1; r[32+12] = 1'b1;
    run(4, 1'b1, r, 1'b0, "R3 unpack halves");
    r = '0;
    for (int k = 0; k < NW*2; k++) r[k*16 +: 16] = 16'hE000;
    run(24, 1'b0, r, 1'b0, "R3 bits above m13");
    for (int k = 0; k < NW*2; k++) r[k*16 +: 16] = 16'hC000;
    run(24, 1'b1, r, 1'b0, "R3 bits above m14");
    r = '0; r[13] = 1'b1;
    run(2, 1'b1, r, 1'b0, "R6 bit13 m14");
    run(0, 1'b0, {NW{32'hFFFF_FFFF}}, 1'b0, "R10 t zero");
    run(31, 1'b1, {NW{32'h1234_5678}}, 1'b0, "R10 t above max");
    for (int w = 0; w < NW; w++) r[w*32 +: 32] = $urandom();
    run(12, 1'b0, r, 1'b0, "R6 m13");
    run(12, 1'b1, r, 1'b1, "R6 m14 poke");
    for (int n = 0; n < 24; n++) begin
      for (int w = 0; w < NW; w++) r[w*32 +: 32] = $urandom();
      run(1 + int'($urandom_range(T_MAX - 1)), 1'($urandom_range(1)), r, n % 6 == 0, "R4 random");
    end
    chk(tbl_bad == 0, "R9", "table request range", tbl_bad, 0);
    summary();
  end
endmodule